// File: doc/BRIEF.md
# Half-Duplex Transmit Collision Controller

This block supervises one transmit attempt on a shared half-duplex medium. A frame request moves the controller into a deferral phase, where it waits for the carrier to clear. It then enters a transmit phase, where a serializer outside the block sends bytes and reports each one through a strobe. The controller keeps a count of the bytes sent in the current attempt.

A collision seen while the byte count is at or below a programmable threshold counts as an early collision. The attempt is dropped and the controller waits a random back-off. The frame is then sent again from its first byte. A collision seen beyond the threshold is a late collision. The frame is dropped at once and is not retried. Other aborts cover too many early collisions and a carrier that stays busy for too long.

When a frame ends, a sticky completion or error flag is raised and a 32-bit status word is stored. A synchronous transmit-logic reset returns the controller to idle from any state.

Top module: `hdx_tx_ctrl`

## Requirements
- R1: After rst_n is released, tx_active, tx_busy, tx_done and tx_err are all 0 and tx_tsv is 0.
- R2: With defer low, a tx_start pulse raises tx_busy after one clock edge. tx_active rises after the second edge.
- R3: A byte_sent strobe with byte_last high during transmit ends the frame successfully. On the next edge tx_done=1, tx_err=0 and tx_busy=0. tx_tsv then holds the attempt's byte count in bits 15:0, the early-collision count in bits 19:16 and bit 24 set.
- R4: A collision with a byte count at or below late_thresh, and fewer than 16 collisions so far, is an early collision. tx_active drops on the next edge while tx_busy stays high. Transmission later resumes with the byte count restarted at zero.
- R5: A collision with a byte count above late_thresh is a late collision. On the next edge tx_busy=0 and tx_err=1, with tx_tsv bits 29 and 27 set, bits 15:0 holding the byte count and bit 24 clear. No further attempt is made.
- R6: The 16th early collision of a frame aborts it. tx_err=1, tx_tsv bit 25 and bit 27 are set, and bits 19:16 read 15.
- R7: If defer is sampled high on MAX_DEFER consecutive edges in the deferral phase, the frame aborts. tx_err=1 and tx_tsv bits 26 and 27 are set. A shorter deferral is followed by normal transmission.
- R8: After the n-th early collision, tx_active stays low for between 2 and (2^min(n,10)-1)*SLOT_CYCLES+2 cycles.
- R9: tx_reset sampled high forces the controller to idle on that edge and clears tx_done and tx_err. The next frame then runs normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_start | input | 1 | Frame request pulse, taken in idle |
| tx_reset | input | 1 | Synchronous transmit-logic reset |
| byte_sent | input | 1 | One byte was sent in this cycle |
| byte_last | input | 1 | Qualifies byte_sent as the final byte of the frame |
| collision | input | 1 | Collision indication from the PHY |
| defer | input | 1 | Carrier busy, so transmission must wait |
| late_thresh | input | BCNT_W | Largest byte count at which a collision still counts as early |
| tx_active | output | 1 | Serializer may send bytes from the start of the frame |
| tx_busy | output | 1 | Request pending (cleared on completion or abort) |
| tx_done | output | 1 | Sticky successful-completion flag |
| tx_err | output | 1 | Sticky abort flag |
| tx_tsv | output | 32 | Transmit status vector of the last finished frame |

## Verification
Every result is registered once.

- Flags, busy and the status word change on the edge that samples the final byte, the collision, or the last deferral cycle. The bench checks them at the following falling edge.
- tx_active follows tx_start by two edges: one to enter deferral and one to leave it. The bench confirms it is still low after the first edge.
- After an early collision, the bench counts falling edges with tx_active low. That count is the loaded back-off plus one timer cycle plus one deferral cycle, and it is compared with the exponent window for that collision number.
- A long deferral is checked edge by edge. tx_busy must still be high after edge MAX_DEFER-1 and low after edge MAX_DEFER.

// File: rtl/hdx_pkg.sv
package hdx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_DEFER   = 2'd1,
    ST_XMIT    = 2'd2,
    ST_BACKOFF = 2'd3
  } hdx_state_t;

  // Status vector layout
  localparam int TSV_BYTES_LSB = 0;
  localparam int TSV_COLL_LSB  = 16;
  localparam int TSV_OK        = 24;
  localparam int TSV_XCOLL     = 25;
  localparam int TSV_XDEFER    = 26;
  localparam int TSV_ABORT     = 27;
  localparam int TSV_LATE      = 29;

  // Slot mask for truncated binary exponential back-off.
  function automatic logic [15:0] bo_mask(input logic [4:0] n, input int unsigned limit);
    int unsigned k;
    k = (int'(n) > limit) ? limit : int'(n);
    return 16'((32'd1 << k) - 32'd1);
  endfunction

  function automatic logic [31:0] pack_tsv(
    input logic [15:0] bytes,
    input logic [3:0]  colls,
    input logic        ok,
    input logic        xcoll,
    input logic        xdefer,
    input logic        late
  );
    logic [31:0] v;
    v = '0;
    v[TSV_BYTES_LSB +: 16] = bytes;
    v[TSV_COLL_LSB +: 4]   = colls;
    v[TSV_OK]              = ok;
    v[TSV_XCOLL]           = xcoll;
    v[TSV_XDEFER]          = xdefer;
    v[TSV_ABORT]           = xcoll | xdefer | late;
    v[TSV_LATE]            = late;
    return v;
  endfunction

endpackage

// File: rtl/hdx_lfsr.sv
module hdx_lfsr #(
  parameter int          WIDTH = 16,
  parameter logic [15:0] SEED  = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [WIDTH-1:0] rnd
);
  logic [15:0] sreg;
  logic        fb;

  assign fb  = sreg[15] ^ sreg[13] ^ sreg[12] ^ sreg[10];
  assign rnd = sreg[WIDTH-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sreg <= (SEED == 16'h0) ? 16'h1 : SEED;
    else        sreg <= {sreg[14:0], fb};
  end

  AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    sreg != 16'h0); // R8
endmodule

// File: rtl/hdx_backoff_timer.sv
module hdx_backoff_timer #(
  parameter int SLOT_W      = 10,
  parameter int SLOT_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic [SLOT_W-1:0] slots,
  output logic              bo_run,
  output logic              bo_done
);
  localparam int MAX_TOTAL = ((1 << SLOT_W) - 1) * SLOT_CYCLES;
  localparam int CNT_W     = $clog2(MAX_TOTAL + 1) + 1;

  logic [CNT_W-1:0] cnt;

  assign bo_done = bo_run && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      bo_run <= 1'b0;
    end else if (clr) begin
      cnt    <= '0;
      bo_run <= 1'b0;
    end else if (load) begin
      cnt    <= CNT_W'(slots) * CNT_W'(SLOT_CYCLES);
      bo_run <= 1'b1;
    end else if (bo_run) begin
      if (cnt == '0) bo_run <= 1'b0;
      else           cnt    <= cnt - 1'b1;
    end
  end

  AST_BO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    bo_run |-> (cnt <= CNT_W'(MAX_TOTAL))); // R8
endmodule

// File: rtl/hdx_tx_ctrl.sv
module hdx_tx_ctrl
  import hdx_pkg::*;
#(
  parameter int          BCNT_W       = 16,
  parameter int          MAX_ATTEMPTS = 16,
  parameter int          BO_LIMIT     = 10,
  parameter int          SLOT_CYCLES  = 64,
  parameter int          MAX_DEFER    = 3000,
  parameter logic [15:0] LFSR_SEED    = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_start,
  input  logic              tx_reset,
  input  logic              byte_sent,
  input  logic              byte_last,
  input  logic              collision,
  input  logic              defer,
  input  logic [BCNT_W-1:0] late_thresh,
  output logic              tx_active,
  output logic              tx_busy,
  output logic              tx_done,
  output logic              tx_err,
  output logic [31:0]       tx_tsv
);
  localparam int CC_W = $clog2(MAX_ATTEMPTS);
  localparam int DC_W = $clog2(MAX_DEFER + 1);

  hdx_state_t        state;
  logic [BCNT_W-1:0] byte_cnt;
  logic [CC_W-1:0]   coll_cnt;
  logic [DC_W-1:0]   defer_cnt;

  logic [15:0]         rnd;
  logic [BO_LIMIT-1:0] bo_slots;
  logic                bo_run, bo_done;

  // Named events for the assertions
  logic ev_coll, ev_early, ev_late, ev_excess, ev_retry, ev_ok, ev_dabort;

  assign ev_coll   = (state == ST_XMIT) && collision;
  assign ev_early  = ev_coll && (byte_cnt <= late_thresh);
  assign ev_late   = ev_coll && (byte_cnt > late_thresh);
  assign ev_excess = ev_early && (coll_cnt == CC_W'(MAX_ATTEMPTS - 1));
  assign ev_retry  = ev_early && !ev_excess;
  assign ev_ok     = (state == ST_XMIT) && !collision && byte_sent && byte_last;
  assign ev_dabort = (state == ST_DEFER) && defer && (defer_cnt == DC_W'(MAX_DEFER - 1));

  assign bo_slots  = rnd[BO_LIMIT-1:0] &
                     bo_mask(5'(coll_cnt) + 5'd1, BO_LIMIT)[BO_LIMIT-1:0];

  assign tx_active = (state == ST_XMIT);
  assign tx_busy   = (state != ST_IDLE);

  hdx_lfsr #(.WIDTH(16), .SEED(LFSR_SEED)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .rnd(rnd)
  );

  hdx_backoff_timer #(.SLOT_W(BO_LIMIT), .SLOT_CYCLES(SLOT_CYCLES)) u_bo (
    .clk(clk), .rst_n(rst_n), .clr(tx_reset), .load(ev_retry && !tx_reset),
    .slots(bo_slots), .bo_run(bo_run), .bo_done(bo_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      byte_cnt  <= '0;
      coll_cnt  <= '0;
      defer_cnt <= '0;
      tx_done   <= 1'b0;
      tx_err    <= 1'b0;
      tx_tsv    <= '0;
    end else if (tx_reset) begin
      state     <= ST_IDLE;
      byte_cnt  <= '0;
      coll_cnt  <= '0;
      defer_cnt <= '0;
      tx_done   <= 1'b0;
      tx_err    <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (tx_start) begin
          state     <= ST_DEFER;
          byte_cnt  <= '0;
          coll_cnt  <= '0;
          defer_cnt <= '0;
          tx_done   <= 1'b0;
          tx_err    <= 1'b0;
        end
        ST_DEFER: begin
          if (ev_dabort) begin
            state  <= ST_IDLE;
            tx_err <= 1'b1;
            tx_tsv <= pack_tsv(16'(byte_cnt), 4'(coll_cnt), 1'b0, 1'b0, 1'b1, 1'b0);
          end else if (defer) begin
            defer_cnt <= defer_cnt + 1'b1;
          end else begin
            state    <= ST_XMIT;
            byte_cnt <= '0;
          end
        end
        ST_XMIT: begin
          if (ev_late) begin
            state  <= ST_IDLE;
            tx_err <= 1'b1;
            tx_tsv <= pack_tsv(16'(byte_cnt), 4'(coll_cnt), 1'b0, 1'b0, 1'b0, 1'b1);
          end else if (ev_excess) begin
            state  <= ST_IDLE;
            tx_err <= 1'b1;
            tx_tsv <= pack_tsv(16'(byte_cnt), 4'(coll_cnt), 1'b0, 1'b1, 1'b0, 1'b0);
          end else if (ev_retry) begin
            state    <= ST_BACKOFF;
            coll_cnt <= coll_cnt + 1'b1;
          end else if (ev_ok) begin
            state   <= ST_IDLE;
            tx_done <= 1'b1;
            tx_tsv  <= pack_tsv(16'(byte_cnt + 1'b1), 4'(coll_cnt), 1'b1, 1'b0, 1'b0, 1'b0);
          end else if (byte_sent) begin
            byte_cnt <= byte_cnt + 1'b1;
          end
        end
        ST_BACKOFF: if (bo_done) begin
          state     <= ST_DEFER;
          defer_cnt <= '0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_reset |=> (!tx_busy && !tx_done && !tx_err)); // R9
  AST_START_DEFER: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && tx_start && !tx_reset) |=> (tx_busy && !tx_active)); // R2
  AST_OK_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ok && !tx_reset) |=> (tx_done && !tx_err && !tx_busy && tx_tsv[TSV_OK])); // R3
  AST_EARLY_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_retry && !tx_reset) |=> (bo_run && tx_busy && !tx_active)); // R4
  AST_LATE_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_late && !tx_reset) |=> (!tx_busy && tx_err && tx_tsv[TSV_LATE] && tx_tsv[TSV_ABORT])); // R5
  AST_EXCESS_COLL: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_excess && !tx_reset) |=> (!tx_busy && tx_err && tx_tsv[TSV_XCOLL])); // R6
  AST_DEFER_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_dabort && !tx_reset) |=> (!tx_busy && tx_err && tx_tsv[TSV_XDEFER])); // R7
  AST_BO_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BACKOFF && bo_done && !tx_reset) |=> (state == ST_DEFER)); // R8
endmodule

// File: tb/sim_hdx_tx_ctrl.sv
module sim_hdx_tx_ctrl;
  localparam int SLOT = 2;
  localparam int MAXD = 20;
  localparam int NV   = 7;
  // Vector table: length, threshold, collision byte index, collided attempts
  localparam int V_LEN [NV] = '{10, 80, 80, 20, 20, 8, 1};
  localparam int V_THR [NV] = '{64, 64, 64,  5,  5, 64, 0};
  localparam int V_CPOS[NV] = '{ 0, 64, 65,  3,  6,  2, 0};
  localparam int V_NCOL[NV] = '{ 0,  1,  1,  3,  1, 16, 1};

  logic clk = 0, rst_n = 0;
  logic tx_start = 0, tx_reset = 0, byte_sent = 0, byte_last = 0, collision = 0, defer = 0;
  logic [15:0] late_thresh = 16'd64;
  logic tx_active, tx_busy, tx_done, tx_err;
  logic [31:0] tx_tsv;
  int n_chk = 0, n_err = 0, cyc = 0;

  always #2.5 clk = ~clk;

  hdx_tx_ctrl #(.BCNT_W(16), .MAX_ATTEMPTS(16), .BO_LIMIT(10), .SLOT_CYCLES(SLOT),
                .MAX_DEFER(MAXD), .LFSR_SEED(16'h1D2B)) u0 (
    .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .tx_reset(tx_reset),
    .byte_sent(byte_sent), .byte_last(byte_last), .collision(collision), .defer(defer),
    .late_thresh(late_thresh), .tx_active(tx_active), .tx_busy(tx_busy),
    .tx_done(tx_done), .tx_err(tx_err), .tx_tsv(tx_tsv)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_tsv(input int bytes, input int colls, input bit ok,
                                          input bit xc, input bit xd, input bit late);
    logic [31:0] v = 32'h0;
    v[15:0]  = 16'(bytes);
    v[19:16] = 4'(colls);
    v[24] = ok; v[25] = xc; v[26] = xd; v[27] = xc | xd | late; v[29] = late;
    return v;
  endfunction

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic start_frame();
    tx_start = 1; step(); tx_start = 0;
    chk(tx_busy && !tx_active, "R2 busy after one edge", {30'h0, tx_busy, tx_active}, 32'h2);
  endtask

  task automatic run_vector(input int len, input int thr, input int cpos, input int ncol);
    bit late_exp, xc_exp, fin;
    int att, gap, lim;
    late_thresh = 16'(thr);
    late_exp = (ncol > 0) && (cpos > thr);
    xc_exp   = (ncol >= 16) && !late_exp;
    start_frame();
    step();
    chk(tx_active, "R2 active after second edge", {31'h0, tx_active}, 32'h1);
    att = 1; fin = 0;
    while (!fin) begin
      for (int i = 0; i < len; i++) begin
        if (att <= ncol && i == cpos) begin
          collision = 1; step(); collision = 0;
          break;
        end
        byte_sent = 1; byte_last = (i == len - 1); step();
        byte_sent = 0; byte_last = 0;
      end
      if (att > ncol || late_exp || att == 16) fin = 1;
      else begin
        chk(!tx_active && tx_busy, "R4 early collision drops active", {30'h0, tx_busy, tx_active}, 32'h2);
        gap = 0;
        while (!tx_active && gap < 5000) begin gap++; step(); end
        lim = ((1 << ((att > 10) ? 10 : att)) - 1) * SLOT + 2;
        chk(gap >= 2 && gap <= lim, "R8 back-off window", gap, lim);
        att++;
      end
    end
    if (late_exp)
      chk(!tx_busy && tx_err && !tx_done && tx_tsv == exp_tsv(cpos, 0, 0, 0, 0, 1),
          "R5 late collision abort", tx_tsv, exp_tsv(cpos, 0, 0, 0, 0, 1));
    else if (xc_exp)
      chk(!tx_busy && tx_err && tx_tsv == exp_tsv(cpos, 15, 0, 1, 0, 0),
          "R6 excessive collisions", tx_tsv, exp_tsv(cpos, 15, 0, 1, 0, 0));
    else
      chk(!tx_busy && tx_done && !tx_err && tx_tsv == exp_tsv(len, ncol, 1, 0, 0, 0),
          (ncol > 0) ? "R4 retry completes with restarted count" : "R3 clean completion",
          tx_tsv, exp_tsv(len, ncol, 1, 0, 0, 0));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; step();
    chk(!tx_active && !tx_busy && !tx_done && !tx_err && tx_tsv == 0, "R1 reset state",
        {tx_tsv[27:0], tx_active, tx_busy, tx_done, tx_err}, 32'h0);

    for (int v = 0; v < NV; v++) begin
      run_vector(V_LEN[v], V_THR[v], V_CPOS[v], V_NCOL[v]);
      step();
    end

    // R7: long deferral aborts on edge MAXD
    late_thresh = 16'd64;
    defer = 1;
    tx_start = 1; step(); tx_start = 0;
    repeat (MAXD - 1) step();
    chk(tx_busy, "R7 still deferring before limit", {31'h0, tx_busy}, 32'h1);
    step();
    chk(!tx_busy && tx_err && tx_tsv == exp_tsv(0, 0, 0, 0, 1, 0), "R7 excessive deferral",
        tx_tsv, exp_tsv(0, 0, 0, 0, 1, 0));
    defer = 0; step();

    // R7: short deferral then normal frame
    defer = 1;
    tx_start = 1; step(); tx_start = 0;
    repeat (9) step();
    chk(!tx_active && tx_busy, "R7 short deferral holds", {30'h0, tx_busy, tx_active}, 32'h2);
    defer = 0; step();
    chk(tx_active, "R7 transmit after deferral", {31'h0, tx_active}, 32'h1);
    for (int i = 0; i < 4; i++) begin
      byte_sent = 1; byte_last = (i == 3); step();
    end
    byte_sent = 0; byte_last = 0;
    chk(tx_done && !tx_err && tx_tsv == exp_tsv(4, 0, 1, 0, 0, 0), "R7 frame after short deferral",
        tx_tsv, exp_tsv(4, 0, 1, 0, 0, 0));

    // R9: transmit-logic reset mid-frame
    start_frame(); step();
    for (int i = 0; i < 5; i++) begin byte_sent = 1; step(); end
    byte_sent = 0;
    tx_reset = 1; step(); tx_reset = 0;
    chk(!tx_busy && !tx_active && !tx_done && !tx_err, "R9 reset forces idle",
        {28'h0, tx_active, tx_busy, tx_done, tx_err}, 32'h0);
    step();
    chk(!tx_busy, "R9 stays idle after release", {31'h0, tx_busy}, 32'h0);
    run_vector(6, 64, 0, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule